// File: doc/BRIEF.md
# YCbCr 4:2:2 Pixel Port Formatter

The formatter takes 4:2:2 video one pixel pair at a time (one blue-difference byte, two luma bytes, one red-difference byte) and places it on an external 16-bit pixel bus. It also produces the clock that travels with that bus. A 4-bit format field picks between two layouts. The narrow layout sends one byte per full-rate clock period on the low lane. The wide layout sends a luma byte and a chroma byte together, one word per half-rate clock period, on the whole bus. Every other format code parks the bus.

The block runs on an internal clock at twice the full-rate pixel clock. A byte slot is two internal cycles and a pixel pair is eight. A full-rate clock and a half-rate clock are generated from one phase counter. The half-rate clock comes from a toggle divider whose phase is fixed by reset. A select field routes one of the two clocks to the output pin, and a polarity bit inverts that pin. A swap bit exchanges the two chroma bytes. The pair, the format, the swap, the polarity and the clock select are all captured together at a pair boundary, so no pair is ever emitted with mixed settings.

Top module: `yc422_pixel_port`

## Requirements
- R1: While reset is held, `pix_bus` is 0, `pix_oe` is 00, `pix_clk` is 0 and `pair_load` is 1. Until the first pair has been captured after reset, the bus stays 0 with `pix_oe` 00.
- R2: With format code 0011 (the default) and swap 0, the low lane `pix_bus[7:0]` carries the bytes Cb, Y0, Cr, Y1 in that order, each held for two internal cycles. `pix_bus[15:8]` is 0 and `pix_oe` is 01.
- R3: With format code 0010 and swap 0, `pix_bus` carries {Y0, Cb} for four internal cycles and then {Y1, Cr} for four cycles, with luma on bits 15:8. `pix_oe` is 11.
- R4: Any format code other than 0011 or 0010 drives `pix_bus` to 0 and `pix_oe` to 00.
- R5: With swap 1, Cr takes the place Cb would have in R2 and R3, and Cb takes the place of Cr.
- R6: When the clock select is not 101 and polarity is 0, `pix_clk` is high in the first internal cycle of every byte slot and low in the second. Its rising edge therefore coincides with each new byte.
- R7: When the clock select is 101 and polarity is 0, `pix_clk` is the half-rate clock. It is high for the first two internal cycles of each half pair and low for the last two, so its rising edge coincides with the start of each Y0 and Y1 word in the wide layout. After reset its first rising edge is at the start of the first pair.
- R8: Polarity 1 inverts `pix_clk` relative to R6 and R7.
- R9: `pair_load` is high in exactly one internal cycle of every eight: the last cycle of a pair, and the cycle right after reset. The pair inputs are sampled at the clock edge that ends that cycle.
- R10: The format, swap, clock select and polarity inputs are sampled only at the same edge as the pair inputs. Changing them at any other time has no effect until the next pair begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the full-rate pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cb_in | input | 8 | Blue-difference byte of the next pair |
| y0_in | input | 8 | First luma byte of the next pair |
| cr_in | input | 8 | Red-difference byte of the next pair |
| y1_in | input | 8 | Second luma byte of the next pair |
| fmt_sel | input | 4 | Output format code |
| swap_cbcr | input | 1 | Exchange Cb and Cr positions |
| clk_pol | input | 1 | Invert the output clock |
| clk_pad_sel | input | 3 | Output clock select (101 selects half rate) |
| pair_load | output | 1 | High in the cycle whose closing edge samples the pair inputs |
| pix_bus | output | 16 | Pixel bus |
| pix_oe | output | 2 | Lane enables: bit 0 low byte, bit 1 high byte |
| pix_clk | output | 1 | Output pixel clock |

## Verification
The assertions take the inputs as sampled on rising edges of `clk` and assume reset is released synchronously to that clock. They also rely only on the port-level contract that lane enables change just after a load edge. The bench changes its inputs on falling edges only. It randomises the pair bytes every cycle and changes the settings at arbitrary offsets inside a pair, including cycles where `pair_load` is low. It visits both layouts with and without swap, several reserved codes, both clock routes and both polarities. This lets the per-cycle model show that a change made mid-pair has no effect before the boundary.

// File: rtl/yc422_pixel_port.sv
module yc422_pixel_port #(
  parameter int BYTE_W = 8,
  parameter int FMT_W = 4,
  parameter int SEL_W = 3,
  parameter logic [3:0] FMT_NARROW = 4'b0011,
  parameter logic [3:0] FMT_WIDE = 4'b0010,
  parameter logic [2:0] SEL_HALF = 3'b101
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [BYTE_W-1:0]     cb_in,
  input  logic [BYTE_W-1:0]     y0_in,
  input  logic [BYTE_W-1:0]     cr_in,
  input  logic [BYTE_W-1:0]     y1_in,
  input  logic [FMT_W-1:0]      fmt_sel,
  input  logic                  swap_cbcr,
  input  logic                  clk_pol,
  input  logic [SEL_W-1:0]      clk_pad_sel,
  output logic                  pair_load,
  output logic [2*BYTE_W-1:0]   pix_bus,
  output logic [1:0]            pix_oe,
  output logic                  pix_clk
);

  localparam int PH_W = 3;
  localparam logic [PH_W-1:0] PH_LAST = '1;

  logic [PH_W-1:0]   ph;
  logic              primed;
  logic [BYTE_W-1:0] cb_q, y0_q, cr_q, y1_q;
  logic [FMT_W-1:0]  fmt_q;
  logic              swap_q, pol_q;
  logic [SEL_W-1:0]  sel_q;
  logic              full_q, half_q;

  assign pair_load = (ph == PH_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_LAST;
      primed <= 1'b0;
      cb_q   <= '0;
      y0_q   <= '0;
      cr_q   <= '0;
      y1_q   <= '0;
      fmt_q  <= FMT_W'(FMT_NARROW);
      swap_q <= 1'b0;
      pol_q  <= 1'b0;
      sel_q  <= '0;
    end else begin
      ph <= ph + 1'b1;
      if (pair_load) begin
        primed <= 1'b1;
        cb_q   <= cb_in;
        y0_q   <= y0_in;
        cr_q   <= cr_in;
        y1_q   <= y1_in;
        fmt_q  <= fmt_sel;
        swap_q <= swap_cbcr;
        pol_q  <= clk_pol;
        sel_q  <= clk_pad_sel;
      end
    end
  end

  // full-rate clock flop and toggle divider for the half-rate clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      half_q <= 1'b0;
    end else begin
      full_q <= ~full_q;
      if (!full_q) half_q <= ~half_q;
    end
  end

  assign pix_clk = pol_q ^ ((sel_q == SEL_W'(SEL_HALF)) ? half_q : full_q);

  logic [BYTE_W-1:0] c_first, c_second, narrow_byte;
  assign c_first  = swap_q ? cr_q : cb_q;
  assign c_second = swap_q ? cb_q : cr_q;

  always_comb begin
    case (ph[2:1])
      2'd0:    narrow_byte = c_first;
      2'd1:    narrow_byte = y0_q;
      2'd2:    narrow_byte = c_second;
      default: narrow_byte = y1_q;
    endcase
  end

  always_comb begin
    pix_bus = '0;
    pix_oe  = 2'b00;
    if (primed) begin
      if (fmt_q == FMT_W'(FMT_NARROW)) begin
        pix_bus[BYTE_W-1:0] = narrow_byte;
        pix_oe = 2'b01;
      end else if (fmt_q == FMT_W'(FMT_WIDE)) begin
        pix_bus = ph[2] ? {y1_q, c_second} : {y0_q, c_first};
        pix_oe = 2'b11;
      end
    end
  end

endmodule

// File: rtl/yc422_pixel_port_chk.sv
module yc422_pixel_port_chk #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                pair_load,
  input logic [2*BYTE_W-1:0] pix_bus,
  input logic [1:0]          pix_oe
);

  a_r9_load_single: assert property (@(posedge clk) disable iff (!rst_n)
    pair_load |=> !pair_load);

  a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_oe == 2'b00) |-> (pix_bus == '0));

  a_r2_upper_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_oe == 2'b01) |-> (pix_bus[2*BYTE_W-1:BYTE_W] == '0));

  a_r10_mode_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pair_load) |-> $stable(pix_oe));

  a_r3_enable_code: assert property (@(posedge clk) disable iff (!rst_n)
    pix_oe != 2'b10);

endmodule

bind yc422_pixel_port yc422_pixel_port_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pair_load(pair_load), .pix_bus(pix_bus), .pix_oe(pix_oe)
);

// File: tb/yc422_pixel_port_bench.sv
module yc422_pixel_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cb_in = 0, y0_in = 0, cr_in = 0, y1_in = 0;
  logic [3:0] fmt_sel = 4'b0011;
  logic swap_cbcr = 0, clk_pol = 0;
  logic [2:0] clk_pad_sel = 0;
  logic pair_load;
  logic [15:0] pix_bus;
  logic [1:0] pix_oe;
  logic pix_clk;

  int checks = 0, fails = 0, cycles = 0;

  always #10 clk = ~clk;

  yc422_pixel_port u_yc422_pixel_port (
    .clk(clk), .rst_n(rst_n), .cb_in(cb_in), .y0_in(y0_in), .cr_in(cr_in), .y1_in(y1_in),
    .fmt_sel(fmt_sel), .swap_cbcr(swap_cbcr), .clk_pol(clk_pol), .clk_pad_sel(clk_pad_sel),
    .pair_load(pair_load), .pix_bus(pix_bus), .pix_oe(pix_oe), .pix_clk(pix_clk)
  );

  // behavioural reference
  int m_ph = 7;
  bit m_primed = 0;
  int m_cb, m_y0, m_cr, m_y1;
  int m_fmt = 3, m_sel = 0;
  bit m_swap = 0, m_pol = 0;
  bit m_mid_change = 0;

  always @(posedge clk) begin
    cycles++;
    if (rst_n) begin
      if (m_ph == 7) begin
        m_cb = cb_in; m_y0 = y0_in; m_cr = cr_in; m_y1 = y1_in;
        m_fmt = fmt_sel; m_swap = swap_cbcr; m_pol = clk_pol; m_sel = clk_pad_sel;
        m_primed = 1; m_ph = 0; m_mid_change = 0;
      end else m_ph++;
    end else begin
      m_ph = 7; m_primed = 0; m_fmt = 3; m_sel = 0; m_swap = 0; m_pol = 0;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic compare_all();
    int e_bus, e_oe, e_clk, c0, c1, slot;
    string dtag, ctag;
    c0 = m_swap ? m_cr : m_cb;
    c1 = m_swap ? m_cb : m_cr;
    slot = m_ph / 2;
    e_bus = 0; e_oe = 0;
    if (m_primed && m_fmt == 3) begin
      e_oe = 1;
      e_bus = (slot == 0) ? c0 : (slot == 1) ? m_y0 : (slot == 2) ? c1 : m_y1;
    end else if (m_primed && m_fmt == 2) begin
      e_oe = 3;
      e_bus = (m_ph < 4) ? (m_y0 * 256 + c0) : (m_y1 * 256 + c1);
    end
    e_clk = (m_sel == 5) ? (((m_ph / 2) % 2) == 0) : ((m_ph % 2) == 0);
    if (m_pol) e_clk = 1 - e_clk;
    if (m_mid_change) dtag = "R10";
    else if (m_swap && e_oe != 0) dtag = "R5";
    else if (m_fmt == 3) dtag = "R2";
    else if (m_fmt == 2) dtag = "R3";
    else dtag = "R4";
    ctag = m_pol ? "R8" : (m_sel == 5) ? "R7" : "R6";
    check({dtag, " bus"}, pix_bus, e_bus);
    check({dtag, " oe"}, pix_oe, e_oe);
    check({ctag, " clk"}, pix_clk, e_clk);
    check("R9 load", pair_load, m_ph == 7);
  endtask

  always @(negedge clk) begin
    if (rst_n) compare_all();
    cb_in <= 8'($urandom); y0_in <= 8'($urandom);
    cr_in <= 8'($urandom); y1_in <= 8'($urandom);
  end

  task automatic set_cfg(input logic [3:0] f, input bit s, input bit p, input logic [2:0] c);
    int skew;
    skew = $urandom_range(0, 7);
    repeat (skew) @(negedge clk);
    if (m_ph != 6 && m_ph != 7) m_mid_change = 1;
    fmt_sel = f; swap_cbcr = s; clk_pol = p; clk_pad_sel = c;
    repeat (40) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 bus", pix_bus, 0);
    check("R1 oe", pix_oe, 0);
    check("R1 clk", pix_clk, 0);
    check("R1 load", pair_load, 1);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    for (int round = 0; round < 3; round++) begin
      set_cfg(4'b0011, 0, 0, 3'b000);
      set_cfg(4'b0011, 1, 0, 3'b000);
      set_cfg(4'b0010, 0, 0, 3'b101);
      set_cfg(4'b0010, 1, 1, 3'b101);
      set_cfg(4'b0000, 0, 0, 3'b000);
      set_cfg(4'b1111, 1, 1, 3'b010);
      set_cfg(4'b0010, 0, 0, 3'b000);
      set_cfg(4'b0011, 0, 1, 3'b101);
      set_cfg(4'b0100, 0, 0, 3'b101);
      set_cfg(4'b0001, 1, 0, 3'b000);
    end
    // mid-run reset: R1 again
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 bus after reset", pix_bus, 0);
    check("R1 oe after reset", pix_oe, 0);
    fmt_sel = 4'b0011; swap_cbcr = 0; clk_pol = 0; clk_pad_sel = 0;
    rst_n = 1'b1;
    repeat (64) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule